// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial EEPROM behind a three-wire slave port: chip select, serial clock and serial data in, plus a data-out pin with an output enable in place of a tri-state driver. Storage is a register array of 64 words of 16 bits. A fast system clock oversamples all three input pins through two-flop synchronizers and finds rising serial-clock edges in its own domain, so the serial clock must stay well below the system clock (each serial phase should last at least four system clocks).

A transaction starts with a start bit, then a two-bit opcode and a six-bit address, sent MSB first. Reads stream words out for as long as chip select stays high. Writes, erases and their whole-array forms are gated by a write-enable latch. They run as a self-timed cycle of `PROG_CYCLES` system clocks, launched when chip select falls. If the master raises chip select again during that cycle, the data-out pin reports the busy or ready state.

Top module: `serial_prom_slave`

## Requirements
- R1: While chip select is high, the first rising serial-clock edge that samples data-in high is taken as the start bit. Rising edges that sample data-in low before that point have no effect.
- R2: The two bits after the start bit are the opcode: 10 reads, 01 writes, 11 erases one word, and 00 selects a special command from the top two address bits (11 enables writes, 00 disables them, 10 erases the whole array, 01 writes the whole array). Commands without data take 9 rising edges and writes take 25. A programming instruction whose bits were not all clocked in before chip select falls leaves the array unchanged.
- R3: For a read, the rising edge that captures the last address bit enables data-out and drives a 0 on it. Each further rising edge presents the next bit of the addressed word, MSB first.
- R4: While chip select stays high, a read runs on into the next address with no extra zero bit, and address 63 is followed by address 0.
- R5: After reset every word reads all ones, writes are disabled and data-out is not enabled.
- R6: Write, erase, erase-all and write-all take effect only after an enable command and not after a disable command. Reads work in either state.
- R7: A write stores the 16 data bits that follow the address, MSB first, at the addressed word.
- R8: An erase sets the addressed word to all ones.
- R9: An erase-all sets every word to all ones.
- R10: A write-all stores its data word at every address.
- R11: If chip select is raised while a programming cycle runs, data-out is enabled and reads 0 until the cycle ends, then 1. Data-out is disabled whenever chip select is low.
- R12: A complete programming instruction starts its cycle on the falling edge of chip select, and the cycle finishes whatever chip select and the serial clock do. Start bits that arrive during the cycle are ignored.
- R13: Once an instruction has all its bits, further serial-clock edges are ignored until chip select goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset; stands in for power-on |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock; bits are taken on its rising edge |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (read data or ready/busy) |
| sdo_oe | output | 1 | Output enable for sdo_o; low means high-impedance |

## Verification
The bench drives the pins and checks them against a behavioural word array with a write-enable flag. It targets these corner cases:
- Leading zero clocks before the start bit: a design that counted them would decode a shifted opcode.
- The dummy zero ahead of the first word only: a design that repeated it would shift every later word by one bit.
- Sequential reads across the word boundary and the wrap from 63 to 0: a wrong address increment shows up as misread data.
- Truncated writes, and extra clocks after a complete write: a design that counted or launched on the wrong edge would corrupt the array.
- A full instruction sent during a busy cycle: a design that accepted it would write a second word.
- Programming attempts before enable and after disable, which must leave the array unchanged.

// File: rtl/serial_prom_slave.sv
module serial_prom_slave #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(DW) + 1;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  localparam logic [1:0] K_ERASE = 2'd0, K_ERAL = 2'd1, K_WRITE = 2'd2, K_WRAL = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_DONE} st_t;

  logic [1:0]    cs_q, ck_q, di_q;
  logic          cs_d, ck_d;
  logic          cs_s, ck_s, di_s, rise, cs_up;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW:0]   cmd;
  logic [AW-1:0] adr;
  logic [DW-1:0] dat, rword;
  logic [1:0]    kind;
  logic          pend, wen, busy, show, dout;
  logic [TW-1:0] tmr;
  logic [DW-1:0] mem [DEPTH];

  logic [AW+1:0] full;
  logic [1:0]    op, sub;
  logic [AW-1:0] fa, nxt;

  assign cs_s  = cs_q[1];
  assign ck_s  = ck_q[1];
  assign di_s  = di_q[1];
  assign rise  = ck_s & ~ck_d;
  assign cs_up = cs_s & ~cs_d;
  assign full  = {cmd, di_s};
  assign op    = full[AW+1:AW];
  assign fa    = full[AW-1:0];
  assign sub   = full[AW-1:AW-2];
  assign nxt   = adr + 1'b1;

  assign sdo_oe = cs_s & ((st == S_READ) | show);
  assign sdo_o  = show ? ~busy : ((st == S_READ) & dout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0; ck_q <= '0; di_q <= '0; cs_d <= 1'b0; ck_d <= 1'b0;
      st <= S_IDLE; cnt <= '0; cmd <= '0; adr <= '0; dat <= '0; rword <= '0;
      kind <= K_ERASE; pend <= 1'b0; wen <= 1'b0; busy <= 1'b0; show <= 1'b0;
      dout <= 1'b0; tmr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      cs_q <= {cs_q[0], cs_i};
      ck_q <= {ck_q[0], sck_i};
      di_q <= {di_q[0], sdi_i};
      cs_d <= cs_s;
      ck_d <= ck_s;

      if (busy) begin
        if (tmr == '0) begin
          busy <= 1'b0;
          case (kind)
            K_ERASE: mem[adr] <= '1;
            K_WRITE: mem[adr] <= dat;
            K_ERAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            default: for (int i = 0; i < DEPTH; i++) mem[i] <= dat;
          endcase
        end else begin
          tmr <= tmr - 1'b1;
        end
      end

      if (!cs_s) begin
        st   <= S_IDLE;
        show <= 1'b0;
        pend <= 1'b0;
        if (pend && wen) begin
          busy <= 1'b1;
          tmr  <= TW'(PROG_CYCLES - 1);
        end
      end else begin
        if (cs_up && busy) show <= 1'b1;
        if (rise) begin
          case (st)
            S_IDLE: if (di_s && !busy) begin
              st <= S_CMD; cnt <= '0; show <= 1'b0;
            end
            S_CMD: begin
              cmd <= full[AW:0];
              cnt <= cnt + 1'b1;
              if (cnt == CW'(AW + 1)) begin
                adr <= fa;
                cnt <= '0;
                st  <= S_DONE;
                case (op)
                  2'b10: begin st <= S_READ; rword <= mem[fa]; dout <= 1'b0; end
                  2'b01: begin st <= S_DATA; kind <= K_WRITE; end
                  2'b11: begin pend <= 1'b1; kind <= K_ERASE; end
                  default: case (sub)
                    2'b11:   wen <= 1'b1;
                    2'b00:   wen <= 1'b0;
                    2'b10:   begin pend <= 1'b1; kind <= K_ERAL; end
                    default: begin st <= S_DATA; kind <= K_WRAL; end
                  endcase
                endcase
              end
            end
            S_DATA: begin
              dat <= {dat[DW-2:0], di_s};
              cnt <= cnt + 1'b1;
              if (cnt == CW'(DW - 1)) begin
                pend <= 1'b1;
                st   <= S_DONE;
              end
            end
            S_READ: begin
              dout <= rword[DW-1];
              if (cnt == CW'(DW - 1)) begin
                cnt   <= '0;
                adr   <= nxt;
                rword <= mem[nxt];
              end else begin
                cnt   <= cnt + 1'b1;
                rword <= {rword[DW-2:0], 1'b0};
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R6
  wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  // R12
  cs_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cs_s));

  // R12
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr != '0) |=> busy);

  // R12
  busy_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_IDLE) |=> st == S_IDLE);

  // R13
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && cs_s) |=> st == S_DONE);
endmodule

// File: tb/tb_serial_prom_slave.sv
`timescale 1ns/1ps
module tb_serial_prom_slave;
  localparam int AW = 6, DW = 16, PC = 1000, DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, oe;
  int total = 0, bad = 0, lowcnt = 0;
  int model [DEPTH];
  bit wen_m = 1'b0;

  serial_prom_slave #(.AW(AW), .DW(DW), .PROG_CYCLES(PC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe(oe));

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(bit b); sdi = b; ticks(6); sck = 1'b1; ticks(8); sck = 1'b0; ticks(2); endtask
  task automatic sel(); cs = 1'b1; ticks(4); endtask
  task automatic desel(); cs = 1'b0; ticks(6); endtask

  task automatic hdr(bit [1:0] op, int a);
    pulse(1'b1); pulse(op[1]); pulse(op[0]);
    for (int i = AW - 1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic dbits(int d, int nb);
    for (int i = DW - 1; i >= DW - nb; i--) pulse(d[i]);
  endtask

  task automatic do_read(int a, int n, int lead, string req);
    sel();
    for (int i = 0; i < lead; i++) pulse(1'b0);
    hdr(2'b10, a);
    chk({req, " dummy oe (R3)"}, oe, 1);
    chk({req, " dummy zero (R3)"}, sdo, 0);
    for (int w = 0; w < n; w++)
      for (int b = DW - 1; b >= 0; b--) begin
        pulse(1'b0);
        chk(req, sdo, model[(a + w) % DEPTH][b]);
      end
    desel();
  endtask

  task automatic special(bit [1:0] s); hdr(2'b00, s << (AW - 2)); endtask

  task automatic prog_write(int a, int d);
    sel(); hdr(2'b01, a); dbits(d, DW); desel(); ticks(PC + 20);
    if (wen_m) model[a] = d;
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    lowcnt = cs ? 0 : lowcnt + 1;
    if (rst_n && lowcnt >= 4) chk("R11 oe off while deselected", oe, 0);
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    ticks(5); rst_n = 1'b1; ticks(5);
    chk("R5 oe after reset", oe, 0);
    do_read(5, 1, 0, "R5 reset contents");

    // R6: write before enable is ignored, no busy status
    sel(); hdr(2'b01, 3); dbits(16'h1234, DW); cs = 1'b0; ticks(6);
    cs = 1'b1; ticks(6); chk("R6 no cycle when disabled", oe, 0); desel();
    do_read(3, 1, 0, "R6 disabled write");

    sel(); special(2'b11); desel(); wen_m = 1'b1;

    // R7 + R11: write with status polling
    sel(); hdr(2'b01, 3); dbits(16'hA5C3, DW); cs = 1'b0; ticks(6);
    cs = 1'b1; ticks(6);
    chk("R11 status oe", oe, 1); chk("R11 busy low", sdo, 0);
    ticks(PC);
    chk("R11 ready oe", oe, 1); chk("R11 ready high", sdo, 1);
    cs = 1'b0; ticks(6); chk("R11 oe off", oe, 0);
    model[3] = 16'hA5C3;
    do_read(3, 1, 0, "R7 write");

    // R13: extra clocks after complete write
    sel(); hdr(2'b01, 4); dbits(16'h0F0F, DW); pulse(1'b1); pulse(1'b1); pulse(1'b1);
    desel(); ticks(PC + 20); model[4] = 16'h0F0F;
    do_read(4, 1, 0, "R13 extra clocks");

    // R2: truncated write
    sel(); hdr(2'b01, 5); dbits(16'h0000, 10); desel(); ticks(PC + 20);
    do_read(5, 1, 0, "R2 truncated write");

    do_read(3, 1, 3, "R1 leading zeros");
    do_read(3, 3, 0, "R4 sequential");
    prog_write(63, 16'hBEEF);
    do_read(63, 2, 0, "R4 wrap");

    // R12: instruction during busy ignored
    sel(); hdr(2'b01, 10); dbits(16'h1111, DW); cs = 1'b0; ticks(6);
    sel(); hdr(2'b01, 11); dbits(16'h2222, DW); desel(); ticks(PC + 20);
    model[10] = 16'h1111;
    do_read(10, 2, 0, "R12 busy ignores start");

    sel(); hdr(2'b11, 3); desel(); ticks(PC + 20); model[3] = 16'hFFFF;
    do_read(3, 1, 0, "R8 erase");

    sel(); special(2'b01); dbits(16'h5A5A, DW); desel(); ticks(PC + 20);
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h5A5A;
    do_read(62, 4, 0, "R10 write all");

    sel(); special(2'b10); desel(); ticks(PC + 20);
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    do_read(10, 1, 0, "R9 erase all");

    sel(); special(2'b00); desel(); wen_m = 1'b0;
    prog_write(7, 16'h0001);
    do_read(7, 1, 0, "R6 after disable");
    finish_up();
  end
endmodule